// File: doc/BRIEF.md
# Protection Entry Configuration Register File

This block holds the control state for a parameterised set of memory protection entries on a 32-bit hart. Each entry owns an 8-bit control byte (read, write and execute permissions, an address-match mode and a lock bit) and one address word. A separate three-bit security register carries a lockdown flag, a deny-by-default flag and a lock-bypass flag. The range decoder and the access checker sit elsewhere; they take their inputs from the flat entry and flag outputs of this block.

A single access port serves software. The port selects a packed control word, which holds four entry bytes, an address word or the security register, and performs a write or a read. Writes pass through a filter that applies the lock rules. Reads are combinational from the stored state. When a write alters a stored byte, a stored address word or one of the two sticky security flags, the block raises a one-cycle invalidate pulse. Downstream translation caches use that pulse to drop cached permissions.

Top module: `prot_entry_regfile`

## Requirements
- R1: After reset, and during any later reset, every control byte, address word and security flag reads zero and `flush_o` is low.
- R2: A control-word write with `acc_sel`=0 and index k stores wdata byte i (bits 8i+7:8i) into entry 4k+i, where byte 0 is least significant. A read returns the same packing. Within an entry byte, bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the match mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two) and bit 7 is the lock.
- R3: With the lockdown flag clear and the bypass flag clear, a byte write to an entry whose lock bit is set is discarded. This holds whether enhanced mode (`enh_en`) is on or off.
- R4: With `enh_en` high and the bypass flag set, a byte write to a locked entry is accepted.
- R5: With `enh_en` high, the lockdown flag set and bypass clear, the new byte alone decides acceptance. It is taken if it sets the lock and clears execute, or if it clears the lock and its bits 2:0 are not 3'b110. Otherwise it is discarded.
- R6: An address-word write (`acc_sel`=1) is discarded when the addressed entry's lock bit is set.
- R7: An address-word write to entry j is discarded when entry j+1 is locked and in top-of-range mode. The highest entry has no successor and is not checked against one.
- R8: A control-word index with no entries, an address index of at least NUM_ENTRIES, or `acc_sel`=3 leaves all state unchanged, and a read of it returns zero.
- R9: `flush_o` is high during the cycle after a write that changed a stored byte or address word. A write of identical data, or a cycle with no write, leaves it low.
- R10: The security register (`acc_sel`=2) has lockdown at bit 0, deny-by-default at bit 1 and bypass at bit 2, and other bits read zero. A write cannot set bypass while bypass is clear and any entry is locked.
- R11: With `enh_en` high, lockdown and deny-by-default stay set once set. A security write with `enh_en` low forces all three flags to zero.
- R12: A security write that changes the lockdown or deny-by-default flag raises `flush_o` in the following cycle.
- R13: A read performed in the same cycle as a write to the same target returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enh_en | input | 1 | Enables enhanced lock rules and security flags |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | 0 control word, 1 address word, 2 security register, 3 none |
| acc_index | input | IDX_W | Word or entry index |
| acc_wdata | input | XLEN | Write data |
| acc_rdata | output | XLEN | Combinational read data |
| cfg_o | output | NUM_ENTRIES*8 | All entry control bytes, entry e at bits 8e+7:8e |
| addr_o | output | NUM_ENTRIES*XLEN | All address words, entry e at slice e |
| sec_lockdown_o | output | 1 | Lockdown flag |
| sec_whitelist_o | output | 1 | Deny-by-default flag |
| sec_bypass_o | output | 1 | Lock-bypass flag |
| flush_o | output | 1 | One-cycle invalidate pulse |

## Verification
A write and a read can land in the same cycle, because the port keeps its target while the write strobe is active and the read path is combinational. The bench drives a changing write and samples `acc_rdata` before the edge, where it expects the old value. It then samples again after the edge, where it expects the new value with `flush_o` raised. A changing write can also arrive right after a pulse. The table walk checks that an identical write following a changing one lets `flush_o` fall back to low.

// File: rtl/prot_entry_pkg.sv
package prot_entry_pkg;
    localparam int CFG_R    = 0;
    localparam int CFG_W    = 1;
    localparam int CFG_X    = 2;
    localparam int CFG_MLO  = 3;
    localparam int CFG_MHI  = 4;
    localparam int CFG_L    = 7;

    localparam int SEC_LD   = 0;
    localparam int SEC_WL   = 1;
    localparam int SEC_BP   = 2;

    // W + X without R: the combination refused for unlocked bytes in lockdown
    localparam logic [2:0] RWX_WX = 3'b110;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_NA4   = 2'd2,
        MODE_NAPOT = 2'd3
    } match_mode_e;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_SEC  = 2'd2,
        SEL_NONE = 2'd3
    } acc_sel_e;
endpackage

// File: rtl/pcfg_byte_gate.sv
module pcfg_byte_gate
    import prot_entry_pkg::*;
(
    input  logic       enh_en,
    input  logic       lockdown,
    input  logic       bypass,
    input  logic       cur_lock,
    input  logic       new_lock,
    input  logic [2:0] new_rwx,
    output logic       allow
);
    logic ld_ok;

    // In lockdown the new byte alone decides: lock without X, or unlocked not W+X
    assign ld_ok = (new_lock && !new_rwx[CFG_X]) || (!new_lock && (new_rwx != RWX_WX));

    always_comb begin
        if (enh_en) begin
            allow = bypass || (!lockdown && !cur_lock) || (lockdown && ld_ok);
        end else begin
            allow = !cur_lock;
        end
    end
endmodule

// File: rtl/paddr_gate.sv
module paddr_gate
    import prot_entry_pkg::*;
#(
    parameter bit HAS_NEXT = 1'b1
) (
    input  logic       own_lock,
    input  logic       next_lock,
    input  logic [1:0] next_mode,
    output logic       allow
);
    logic next_guard;

    generate
        if (HAS_NEXT) begin : g_next
            assign next_guard = next_lock && (match_mode_e'(next_mode) == MODE_TOR);
        end else begin : g_last
            logic unused_next;
            assign unused_next = next_lock ^ (^next_mode);
            assign next_guard  = 1'b0;
        end
    endgenerate

    assign allow = !own_lock && !next_guard;
endmodule

// File: rtl/psec_next.sv
module psec_next
    import prot_entry_pkg::*;
(
    input  logic       enh_en,
    input  logic       any_locked,
    input  logic       ld_q,
    input  logic       wl_q,
    input  logic       bp_q,
    input  logic [2:0] wbits,
    output logic       ld_d,
    output logic       wl_d,
    output logic       bp_d,
    output logic       sticky_changed
);
    logic bp_req;

    // Bypass may only be raised while it is already set or nothing is locked
    assign bp_req = wbits[SEC_BP] && (bp_q || !any_locked);

    always_comb begin
        if (enh_en) begin
            ld_d = wbits[SEC_LD] || ld_q;
            wl_d = wbits[SEC_WL] || wl_q;
            bp_d = bp_req;
        end else begin
            ld_d = 1'b0;
            wl_d = 1'b0;
            bp_d = 1'b0;
        end
        sticky_changed = (ld_d != ld_q) || (wl_d != wl_q);
    end
endmodule

// File: rtl/prot_entry_regfile.sv
module prot_entry_regfile
    import prot_entry_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int XLEN        = 32,
    parameter int IDX_W       = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enh_en,
    input  logic                        acc_valid,
    input  logic                        acc_write,
    input  logic [1:0]                  acc_sel,
    input  logic [IDX_W-1:0]            acc_index,
    input  logic [XLEN-1:0]             acc_wdata,
    output logic [XLEN-1:0]             acc_rdata,
    output logic [NUM_ENTRIES*8-1:0]    cfg_o,
    output logic [NUM_ENTRIES*XLEN-1:0] addr_o,
    output logic                        sec_lockdown_o,
    output logic                        sec_whitelist_o,
    output logic                        sec_bypass_o,
    output logic                        flush_o
);
    localparam int BPW = XLEN / 8;

    typedef struct packed {
        logic [NUM_ENTRIES-1:0][7:0]      cfg;
        logic [NUM_ENTRIES-1:0][XLEN-1:0] addr;
        logic                             ld;
        logic                             wl;
        logic                             bp;
        logic                             flush;
    } state_t;

    state_t st_q, st_d;

    logic [NUM_ENTRIES-1:0]      cfg_word_hit;
    logic [NUM_ENTRIES-1:0]      addr_hit;
    logic [NUM_ENTRIES-1:0][7:0] cfg_new;
    logic [NUM_ENTRIES-1:0]      cfg_allow;
    logic [NUM_ENTRIES-1:0]      addr_allow;
    logic [NUM_ENTRIES-1:0]      lock_vec;
    logic                        any_locked;
    logic                        sec_ld_n, sec_wl_n, sec_bp_n, sec_sticky_chg;
    logic                        do_write;
    acc_sel_e                    sel;

    assign sel      = acc_sel_e'(acc_sel);
    assign do_write = acc_valid && acc_write;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        localparam int WORD = e / BPW;
        localparam int LANE = e % BPW;

        assign lock_vec[e]     = st_q.cfg[e][CFG_L];
        assign cfg_word_hit[e] = (acc_index == IDX_W'(WORD));
        assign addr_hit[e]     = (acc_index == IDX_W'(e));
        assign cfg_new[e]      = acc_wdata[LANE*8 +: 8];

        pcfg_byte_gate u_byte_gate (
            .enh_en   (enh_en),
            .lockdown (st_q.ld),
            .bypass   (st_q.bp),
            .cur_lock (st_q.cfg[e][CFG_L]),
            .new_lock (cfg_new[e][CFG_L]),
            .new_rwx  (cfg_new[e][CFG_X:CFG_R]),
            .allow    (cfg_allow[e])
        );

        if (e < NUM_ENTRIES - 1) begin : g_mid
            paddr_gate #(.HAS_NEXT(1'b1)) u_addr_gate (
                .own_lock  (st_q.cfg[e][CFG_L]),
                .next_lock (st_q.cfg[e+1][CFG_L]),
                .next_mode (st_q.cfg[e+1][CFG_MHI:CFG_MLO]),
                .allow     (addr_allow[e])
            );
        end else begin : g_top
            paddr_gate #(.HAS_NEXT(1'b0)) u_addr_gate (
                .own_lock  (st_q.cfg[e][CFG_L]),
                .next_lock (1'b0),
                .next_mode (2'b00),
                .allow     (addr_allow[e])
            );
        end
    end

    assign any_locked = |lock_vec;

    psec_next u_sec_next (
        .enh_en         (enh_en),
        .any_locked     (any_locked),
        .ld_q           (st_q.ld),
        .wl_q           (st_q.wl),
        .bp_q           (st_q.bp),
        .wbits          (acc_wdata[2:0]),
        .ld_d           (sec_ld_n),
        .wl_d           (sec_wl_n),
        .bp_d           (sec_bp_n),
        .sticky_changed (sec_sticky_chg)
    );

    // Next-state process
    always_comb begin
        logic changed;
        st_d       = st_q;
        st_d.flush = 1'b0;
        changed    = 1'b0;
        if (do_write) begin
            case (sel)
                SEL_CFG: begin
                    for (int e = 0; e < NUM_ENTRIES; e++) begin
                        if (cfg_word_hit[e] && cfg_allow[e] && (cfg_new[e] != st_q.cfg[e])) begin
                            st_d.cfg[e] = cfg_new[e];
                            changed     = 1'b1;
                        end
                    end
                end
                SEL_ADDR: begin
                    for (int e = 0; e < NUM_ENTRIES; e++) begin
                        if (addr_hit[e] && addr_allow[e] && (acc_wdata != st_q.addr[e])) begin
                            st_d.addr[e] = acc_wdata;
                            changed      = 1'b1;
                        end
                    end
                end
                SEL_SEC: begin
                    st_d.ld = sec_ld_n;
                    st_d.wl = sec_wl_n;
                    st_d.bp = sec_bp_n;
                    changed = sec_sticky_chg;
                end
                default: ;
            endcase
        end
        st_d.flush = changed;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Combinational read path
    always_comb begin
        acc_rdata = '0;
        case (sel)
            SEL_CFG: begin
                for (int e = 0; e < NUM_ENTRIES; e++) begin
                    if (cfg_word_hit[e]) acc_rdata[(e % BPW)*8 +: 8] = st_q.cfg[e];
                end
            end
            SEL_ADDR: begin
                for (int e = 0; e < NUM_ENTRIES; e++) begin
                    if (addr_hit[e]) acc_rdata = st_q.addr[e];
                end
            end
            SEL_SEC: begin
                acc_rdata[SEC_LD] = st_q.ld;
                acc_rdata[SEC_WL] = st_q.wl;
                acc_rdata[SEC_BP] = st_q.bp;
            end
            default: ;
        endcase
    end

    assign cfg_o           = st_q.cfg;
    assign addr_o          = st_q.addr;
    assign sec_lockdown_o  = st_q.ld;
    assign sec_whitelist_o = st_q.wl;
    assign sec_bypass_o    = st_q.bp;
    assign flush_o         = st_q.flush;
endmodule

// File: rtl/prot_entry_regfile_chk.sv
module prot_entry_regfile_chk #(
    parameter int NUM_ENTRIES = 16,
    parameter int XLEN        = 32,
    parameter int IDX_W       = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        enh_en,
    input logic                        acc_valid,
    input logic                        acc_write,
    input logic [1:0]                  acc_sel,
    input logic [IDX_W-1:0]            acc_index,
    input logic [NUM_ENTRIES*8-1:0]    cfg_o,
    input logic [NUM_ENTRIES*XLEN-1:0] addr_o,
    input logic                        sec_lockdown_o,
    input logic                        sec_whitelist_o,
    input logic                        sec_bypass_o,
    input logic                        flush_o
);
    logic any_lock;
    logic addr_wr_to_locked;
    logic sec_clear_wr;

    always_comb begin
        any_lock          = 1'b0;
        addr_wr_to_locked = 1'b0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            any_lock = any_lock | cfg_o[e*8+7];
            if (acc_valid && acc_write && (acc_sel == 2'd1) &&
                (acc_index == IDX_W'(e)) && cfg_o[e*8+7])
                addr_wr_to_locked = 1'b1;
        end
    end

    assign sec_clear_wr = acc_valid && acc_write && (acc_sel == 2'd2) && !enh_en;

    // R9: no write, no pulse
    a_r9_no_write_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_write) |=> !flush_o);

    // R9 / R12: a pulse always follows a visible change
    a_r9_flush_has_change: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> ((cfg_o != $past(cfg_o)) || (addr_o != $past(addr_o)) ||
                     (sec_lockdown_o != $past(sec_lockdown_o)) ||
                     (sec_whitelist_o != $past(sec_whitelist_o))));

    // R11: sticky flags only drop through a write with enhanced mode off
    a_r11_lockdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_lockdown_o && !sec_clear_wr) |=> sec_lockdown_o);

    a_r11_whitelist_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_whitelist_o && !sec_clear_wr) |=> sec_whitelist_o);

    // R10: bypass cannot rise while any entry is locked
    a_r10_bypass_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_bypass_o && any_lock) |=> !sec_bypass_o);

    // R6: address words hold across a write to a locked entry
    a_r6_locked_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr_to_locked |=> $stable(addr_o));
endmodule

bind prot_entry_regfile prot_entry_regfile_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .XLEN        (XLEN),
    .IDX_W       (IDX_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enh_en          (enh_en),
    .acc_valid       (acc_valid),
    .acc_write       (acc_write),
    .acc_sel         (acc_sel),
    .acc_index       (acc_index),
    .cfg_o           (cfg_o),
    .addr_o          (addr_o),
    .sec_lockdown_o  (sec_lockdown_o),
    .sec_whitelist_o (sec_whitelist_o),
    .sec_bypass_o    (sec_bypass_o),
    .flush_o         (flush_o)
);

// File: tb/tb_prot_entry_regfile.sv
module tb_prot_entry_regfile;
    localparam int N     = 16;
    localparam int XLEN  = 32;
    localparam int IDX_W = 6;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 enh_en;
    logic                 acc_valid;
    logic                 acc_write;
    logic [1:0]           acc_sel;
    logic [IDX_W-1:0]     acc_index;
    logic [XLEN-1:0]      acc_wdata;
    logic [XLEN-1:0]      acc_rdata;
    logic [N*8-1:0]       cfg_o;
    logic [N*XLEN-1:0]    addr_o;
    logic                 sec_lockdown_o, sec_whitelist_o, sec_bypass_o, flush_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    prot_entry_regfile #(.NUM_ENTRIES(N), .XLEN(XLEN), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_sel(acc_sel), .acc_index(acc_index),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .cfg_o(cfg_o), .addr_o(addr_o),
        .sec_lockdown_o(sec_lockdown_o), .sec_whitelist_o(sec_whitelist_o),
        .sec_bypass_o(sec_bypass_o), .flush_o(flush_o)
    );

    typedef struct packed {
        logic [1:0]       sel;
        logic [IDX_W-1:0] idx;
        logic [31:0]      wdata;
        logic             enh;
        logic [31:0]      exp;
        logic             exp_flush;
        logic [7:0]       req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 6'd0,  32'h44332211, 1'b1, 32'h44332211, 1'b1, 8'd2 },  // R2 packing
        '{2'd1, 6'd5,  32'h12345678, 1'b1, 32'h12345678, 1'b1, 8'd6 },  // R6 unlocked accepted
        '{2'd1, 6'd5,  32'h12345678, 1'b1, 32'h12345678, 1'b0, 8'd9 },  // R9 identical, no pulse
        '{2'd0, 6'd1,  32'h00008800, 1'b1, 32'h00008800, 1'b1, 8'd2 },  // R2 entry5 locked TOR
        '{2'd1, 6'd4,  32'h0000AAAA, 1'b1, 32'h00000000, 1'b0, 8'd7 },  // R7 guarded by next
        '{2'd1, 6'd5,  32'h00000001, 1'b1, 32'h12345678, 1'b0, 8'd6 },  // R6 own lock
        '{2'd0, 6'd1,  32'h00000000, 1'b1, 32'h00008800, 1'b0, 8'd3 },  // R3 locked byte kept
        '{2'd2, 6'd0,  32'h00000004, 1'b1, 32'h00000000, 1'b0, 8'd10},  // R10 bypass refused
        '{2'd2, 6'd0,  32'h00000001, 1'b1, 32'h00000001, 1'b1, 8'd12},  // R12 lockdown set
        '{2'd2, 6'd0,  32'h00000000, 1'b1, 32'h00000001, 1'b0, 8'd11},  // R11 sticky
        '{2'd0, 6'd1,  32'h00008100, 1'b1, 32'h00008100, 1'b1, 8'd5 },  // R5 lock w/o X taken
        '{2'd0, 6'd1,  32'h00008500, 1'b1, 32'h00008100, 1'b0, 8'd5 },  // R5 lock with X refused
        '{2'd0, 6'd1,  32'h00000600, 1'b1, 32'h00008100, 1'b0, 8'd5 },  // R5 unlocked W+X refused
        '{2'd0, 6'd1,  32'h00000300, 1'b1, 32'h00000300, 1'b1, 8'd5 },  // R5 unlocked RW taken
        '{2'd0, 6'd4,  32'hFFFFFFFF, 1'b1, 32'h00000000, 1'b0, 8'd8 },  // R8 empty cfg word
        '{2'd1, 6'd16, 32'hFFFFFFFF, 1'b1, 32'h00000000, 1'b0, 8'd8 },  // R8 addr index too high
        '{2'd3, 6'd0,  32'hFFFFFFFF, 1'b1, 32'h00000000, 1'b0, 8'd8 },  // R8 no target
        '{2'd2, 6'd0,  32'h00000007, 1'b0, 32'h00000000, 1'b1, 8'd11},  // R11 forced clear
        '{2'd1, 6'd15, 32'h0000BEEF, 1'b1, 32'h0000BEEF, 1'b1, 8'd7 }   // R7 last entry
    };

    task automatic check(input bit ok, input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_chk(input logic [1:0] sel, input logic [IDX_W-1:0] idx,
                          input logic [31:0] wd, input logic en,
                          input logic [31:0] exp, input logic ef, input int req);
        @(negedge clk);
        enh_en = en; acc_valid = 1'b1; acc_write = 1'b1;
        acc_sel = sel; acc_index = idx; acc_wdata = wd;
        @(negedge clk);
        acc_write = 1'b0;
        #1;
        check(acc_rdata == exp, req, "rdata", acc_rdata, exp);
        check(flush_o == ef, req, "flush", {31'd0, flush_o}, {31'd0, ef});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(cfg_o == '0 && addr_o == '0, 1, "state zero", cfg_o[31:0], 32'd0);
        check(!flush_o && !sec_lockdown_o && !sec_whitelist_o && !sec_bypass_o,
              1, "flags zero", {28'd0, flush_o, sec_bypass_o, sec_whitelist_o, sec_lockdown_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; enh_en = 1'b1; acc_valid = 1'b0; acc_write = 1'b0;
        acc_sel = 2'd0; acc_index = '0; acc_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(cfg_o == '0 && addr_o == '0, 1, "reset state", cfg_o[31:0], 32'd0);
        check(!flush_o && !sec_lockdown_o && !sec_whitelist_o && !sec_bypass_o,
              1, "reset flags", {31'd0, flush_o}, 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            wr_chk(VECS[v].sel, VECS[v].idx, VECS[v].wdata, VECS[v].enh,
                   VECS[v].exp, VECS[v].exp_flush, int'(VECS[v].req));
        end

        // R13: read during write returns the old word, new word afterwards
        @(negedge clk);
        enh_en = 1'b1; acc_valid = 1'b1; acc_write = 1'b1;
        acc_sel = 2'd0; acc_index = 6'd0; acc_wdata = 32'h44332255;
        #1;
        check(acc_rdata == 32'h44332211, 13, "read during write", acc_rdata, 32'h44332211);
        @(negedge clk);
        acc_write = 1'b0;
        #1;
        check(acc_rdata == 32'h44332255, 13, "read after write", acc_rdata, 32'h44332255);
        check(flush_o, 9, "flush after change", {31'd0, flush_o}, 32'd1);

        // R1: reset in mid-run clears everything
        do_reset();

        // R4: bypass set before any lock lets a locked byte be rewritten
        wr_chk(2'd2, 6'd0, 32'h00000004, 1'b1, 32'h00000004, 1'b0, 4);
        wr_chk(2'd0, 6'd0, 32'h00000080, 1'b1, 32'h00000080, 1'b1, 4);
        wr_chk(2'd0, 6'd0, 32'h00000001, 1'b1, 32'h00000001, 1'b1, 4);   // R4

        // R3 in standard mode, R11 clear, R10 refusal after lock
        do_reset();
        wr_chk(2'd0, 6'd0, 32'h00000080, 1'b0, 32'h00000080, 1'b1, 3);
        wr_chk(2'd0, 6'd0, 32'h00000001, 1'b0, 32'h00000080, 1'b0, 3);   // R3
        wr_chk(2'd2, 6'd0, 32'h00000004, 1'b0, 32'h00000000, 1'b0, 11);  // R11
        wr_chk(2'd2, 6'd0, 32'h00000004, 1'b1, 32'h00000000, 1'b0, 10);  // R10

        // R12 / R11: deny-by-default flag
        wr_chk(2'd2, 6'd0, 32'h00000002, 1'b1, 32'h00000002, 1'b1, 12);  // R12
        wr_chk(2'd2, 6'd0, 32'h00000000, 1'b1, 32'h00000002, 1'b0, 11);  // R11

        acc_valid = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule